// File: doc/BRIEF.md
# Integer Issue Interlock Scoreboard

This block decides, in every cycle, whether a single-issue in-order integer pipeline may let the instruction now presented go ahead. Each presented instruction carries a producer class (the kind of result it will make), a consumer class (how it reads its operands), a destination register and up to two source registers. The scoreboard remembers, for every general register and for the HI/LO accumulator, how many cycles remain until a result in flight can be read. It raises `stall` whenever one of the sources is not yet readable for this particular producer/consumer pairing.

The wait depends on both ends of the dependency. Any result used as the base of a load, store or prefetch address costs one more cycle than an ordinary use. A general-register product feeding a multiply-accumulate is forwarded almost at once. A write to HI/LO holds back a following multiply-accumulate for two cycles. Execution, forwarding paths and exceptions lie outside the block.

Top module: `iss_interlock`

## Requirements
- R1: Producer class codes on `in_prod` are 0 none, 1 load, 2 arithmetic/logic/shift, 3 multiply writing a general register, 4 move from HI/LO, 5 move to HI/LO, 6 multi-instruction sequence. Consumer class codes on `in_cons` are 0 ordinary, 1 load/store address base, 2 prefetch address, 3 multiply-accumulate. A distance of d means the consumer is accepted d clock edges after the producer was accepted.
- R2: After reset no register and no accumulator is pending, so any presented instruction is accepted.
- R3: `stall` is combinational and is never high while `in_valid` is low; `accept` equals `in_valid` and not `stall`.
- R4: A load result needs distance 2 for an ordinary consumer and 3 for an address-base or prefetch consumer.
- R5: Arithmetic and multi-instruction results need distance 1 for ordinary use and 2 as an address base.
- R6: Multiply-to-register and move-from-HI/LO results need distance 5 for ordinary use and 6 as an address base.
- R7: The extra address cycle applies only to source A under consumer codes 1 and 2; source B (store data) always uses the ordinary distance.
- R8: Under consumer code 3, a source produced by a multiply-to-register needs only distance 1.
- R9: A move to HI/LO writes no general register; a consumer with code 3 waits until distance 2 from it.
- R10: Register 0 never causes a stall and is never recorded as pending.
- R11: An instruction that is stalled records nothing; only accepted producers update the scoreboard.
- R12: Every pending count drops by one each cycle, also in cycles where the pipeline is stalled.
- R13: A newer producer of a register replaces the older pending entry for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_prod | input | 3 | Producer class code (R1) |
| in_cons | input | 2 | Consumer class code (R1) |
| in_dst | input | 5 | Destination general register |
| in_src_a | input | 5 | Source A (address base when the consumer code is 1 or 2) |
| in_src_a_en | input | 1 | Source A is read |
| in_src_b | input | 5 | Source B (data operand) |
| in_src_b_en | input | 1 | Source B is read |
| stall | output | 1 | Instruction must wait this cycle |
| accept | output | 1 | Instruction issues this cycle |

## Verification
The bench builds the block with its default parameters: 32 registers, a three-bit countdown, and the default latencies of one, two, five and six cycles plus the one-cycle linked-accumulate and two-cycle accumulator waits. With these values each latency boundary can be reached in a handful of cycles. Both register 0 and register 31 fall inside the tested index range. The bench can also hold a stalled instruction for several cycles and then withdraw it, to show that it was never recorded.

// File: rtl/iss_pkg.sv
`timescale 1ns/1ps
package iss_pkg;
  typedef enum logic [2:0] {
    PC_NONE  = 3'd0,
    PC_LOAD  = 3'd1,
    PC_ALU   = 3'd2,
    PC_MULG  = 3'd3,
    PC_MFHL  = 3'd4,
    PC_MTHL  = 3'd5,
    PC_MULTI = 3'd6
  } prod_e;

  typedef enum logic [1:0] {
    CU_PLAIN = 2'd0,
    CU_ADDR  = 2'd1,
    CU_PREF  = 2'd2,
    CU_ACC   = 2'd3
  } cons_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/iss_lat_table.sv
`timescale 1ns/1ps
// Maps a producer class to the countdown value loaded on acceptance.
module iss_lat_table #(
  parameter int CNT_W       = 3,
  parameter int LAT_LOAD    = 2,
  parameter int LAT_ALU     = 1,
  parameter int LAT_MULG    = 5,
  parameter int LAT_MFHL    = 5,
  parameter int LAT_MULTI   = 1,
  parameter int ADDR_EXTRA  = 1
) (
  input  iss_pkg::prod_e   prod,
  output logic             gpr_wr,
  output logic             hl_wr,
  output logic [CNT_W-1:0] load_val
);
  import iss_pkg::*;

  // Countdown starts at (address-base latency - 1) so that it reaches zero
  // exactly when an address-base consumer may go.
  localparam logic [CNT_W-1:0] V_LOAD  = CNT_W'(LAT_LOAD  + ADDR_EXTRA - 1);
  localparam logic [CNT_W-1:0] V_ALU   = CNT_W'(LAT_ALU   + ADDR_EXTRA - 1);
  localparam logic [CNT_W-1:0] V_MULG  = CNT_W'(LAT_MULG  + ADDR_EXTRA - 1);
  localparam logic [CNT_W-1:0] V_MFHL  = CNT_W'(LAT_MFHL  + ADDR_EXTRA - 1);
  localparam logic [CNT_W-1:0] V_MULTI = CNT_W'(LAT_MULTI + ADDR_EXTRA - 1);

  always_comb begin
    gpr_wr   = 1'b0;
    hl_wr    = 1'b0;
    load_val = '0;
    unique case (prod)
      PC_LOAD:  begin gpr_wr = 1'b1; load_val = V_LOAD;  end
      PC_ALU:   begin gpr_wr = 1'b1; load_val = V_ALU;   end
      PC_MULG:  begin gpr_wr = 1'b1; load_val = V_MULG;  end
      PC_MFHL:  begin gpr_wr = 1'b1; load_val = V_MFHL;  end
      PC_MULTI: begin gpr_wr = 1'b1; load_val = V_MULTI; end
      PC_MTHL:  hl_wr = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/iss_reg_entry.sv
`timescale 1ns/1ps
// One pending-result slot: a saturating down-counter plus the producer class.
module iss_reg_entry #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  iss_pkg::prod_e   wr_tag,
  output logic [CNT_W-1:0] cnt,
  output iss_pkg::prod_e   tag
);
  import iss_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tag <= PC_NONE;
    end else if (wr) begin
      cnt <= wr_val;
      tag <= wr_tag;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R12: without a new write, a pending count falls by exactly one per cycle
  assert_count_down_R12: assert property (@(posedge clk) disable iff (rst)
    (!wr && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R12: an idle slot stays idle until written
  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (rst)
    (!wr && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/iss_src_check.sv
`timescale 1ns/1ps
// Decides whether one source operand is still blocked by its pending entry.
module iss_src_check #(
  parameter int CNT_W        = 3,
  parameter int IDX_W        = 5,
  parameter int LAT_MULG     = 5,
  parameter int LAT_MULG_ACC = 1,
  parameter int ADDR_EXTRA   = 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             en,
  input  logic             addr_path,
  input  logic             acc_path,
  input  logic [CNT_W-1:0] cnt,
  input  iss_pkg::prod_e   tag,
  output logic             blocked
);
  import iss_pkg::*;

  // Remaining count at which a consumer becomes free: elapsed = base latency - cnt.
  localparam logic [CNT_W-1:0] ORD_THR = CNT_W'(ADDR_EXTRA);
  localparam logic [CNT_W-1:0] ACC_THR = CNT_W'(LAT_MULG + ADDR_EXTRA - LAT_MULG_ACC);

  logic live;
  assign live = en && (idx != '0);

  always_comb begin
    if (!live)                            blocked = 1'b0;
    else if (addr_path)                   blocked = (cnt != '0);
    else if (acc_path && tag == PC_MULG)  blocked = (cnt > ACC_THR);
    else                                  blocked = (cnt > ORD_THR);
  end
endmodule

// File: rtl/iss_interlock.sv
`timescale 1ns/1ps
module iss_interlock #(
  parameter int NUM_REGS     = 32,
  parameter int LAT_LOAD     = 2,
  parameter int LAT_ALU      = 1,
  parameter int LAT_MULG     = 5,
  parameter int LAT_MFHL     = 5,
  parameter int LAT_MULTI    = 1,
  parameter int LAT_MTHL_ACC = 2,
  parameter int LAT_MULG_ACC = 1,
  parameter int ADDR_EXTRA   = 1,
  localparam int IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       in_prod,
  input  logic [1:0]       in_cons,
  input  logic [IDX_W-1:0] in_dst,
  input  logic [IDX_W-1:0] in_src_a,
  input  logic             in_src_a_en,
  input  logic [IDX_W-1:0] in_src_b,
  input  logic             in_src_b_en,
  output logic             stall,
  output logic             accept
);
  import iss_pkg::*;

  localparam int MAX_LB = imax(imax(imax(LAT_LOAD, LAT_ALU), imax(LAT_MULG, LAT_MFHL)),
                               imax(LAT_MULTI, LAT_MTHL_ACC)) + ADDR_EXTRA;
  localparam int CNT_W  = $clog2(MAX_LB + 1);
  localparam logic [CNT_W-1:0] HL_VAL = CNT_W'(LAT_MTHL_ACC - 1);

  prod_e prod_w;
  cons_e cons_w;
  assign prod_w = prod_e'(in_prod);
  assign cons_w = cons_e'(in_cons);

  logic             gpr_wr, hl_wr;
  logic [CNT_W-1:0] load_val;

  iss_lat_table #(
    .CNT_W(CNT_W), .LAT_LOAD(LAT_LOAD), .LAT_ALU(LAT_ALU), .LAT_MULG(LAT_MULG),
    .LAT_MFHL(LAT_MFHL), .LAT_MULTI(LAT_MULTI), .ADDR_EXTRA(ADDR_EXTRA)
  ) u_lat (
    .prod(prod_w), .gpr_wr(gpr_wr), .hl_wr(hl_wr), .load_val(load_val)
  );

  logic [CNT_W-1:0] cnt_q [NUM_REGS];
  prod_e            tag_q [NUM_REGS];

  // Slot 0 is hard-wired idle; every other slot is a real entry.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    if (g == 0) begin : g_zero
      assign cnt_q[g] = '0;
      assign tag_q[g] = PC_NONE;
    end else begin : g_live
      logic wr_g;
      assign wr_g = accept && gpr_wr && (in_dst == IDX_W'(g));
      iss_reg_entry #(.CNT_W(CNT_W)) u_ent (
        .clk(clk), .rst(rst), .wr(wr_g), .wr_val(load_val), .wr_tag(prod_w),
        .cnt(cnt_q[g]), .tag(tag_q[g])
      );
    end
  end

  // Accumulator slot: only a move to HI/LO fills it.
  logic [CNT_W-1:0] hl_cnt;
  always_ff @(posedge clk) begin
    if (rst)                   hl_cnt <= '0;
    else if (accept && hl_wr)  hl_cnt <= HL_VAL;
    else if (hl_cnt != '0)     hl_cnt <= hl_cnt - CNT_W'(1);
  end

  logic addr_a, acc_c, blk_a, blk_b, blk_hl;
  assign addr_a = (cons_w == CU_ADDR) || (cons_w == CU_PREF);
  assign acc_c  = (cons_w == CU_ACC);

  iss_src_check #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .LAT_MULG(LAT_MULG),
    .LAT_MULG_ACC(LAT_MULG_ACC), .ADDR_EXTRA(ADDR_EXTRA)
  ) u_chk_a (
    .idx(in_src_a), .en(in_src_a_en), .addr_path(addr_a), .acc_path(acc_c),
    .cnt(cnt_q[in_src_a]), .tag(tag_q[in_src_a]), .blocked(blk_a)
  );

  iss_src_check #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .LAT_MULG(LAT_MULG),
    .LAT_MULG_ACC(LAT_MULG_ACC), .ADDR_EXTRA(ADDR_EXTRA)
  ) u_chk_b (
    .idx(in_src_b), .en(in_src_b_en), .addr_path(1'b0), .acc_path(acc_c),
    .cnt(cnt_q[in_src_b]), .tag(tag_q[in_src_b]), .blocked(blk_b)
  );

  assign blk_hl = acc_c && (hl_cnt != '0);
  assign stall  = in_valid && (blk_a || blk_b || blk_hl);
  assign accept = in_valid && !stall;

  // R3: no stall without a presented instruction
  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !stall);

  // R10: operands that are absent or register 0 never hold up a non-accumulate consumer
  assert_r0_free_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!in_src_a_en || in_src_a == '0) && (!in_src_b_en || in_src_b == '0)
     && cons_w != CU_ACC) |-> !stall);

  // R4: a load base consumer one cycle after an accepted load must wait
  assert_load_base_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && prod_w == PC_LOAD && in_dst != '0) |=>
    (!(in_valid && cons_w == CU_ADDR && in_src_a_en && in_src_a == $past(in_dst)) || stall));

  // R9: an accumulate right after a move to HI/LO must wait
  assert_acc_after_hl_R9: assert property (@(posedge clk) disable iff (rst)
    (accept && prod_w == PC_MTHL) |=> (!(in_valid && cons_w == CU_ACC) || stall));
endmodule

// File: tb/sim_iss_interlock.sv
`timescale 1ns/1ps
module sim_iss_interlock;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [2:0] in_prod;
  logic [1:0] in_cons;
  logic [4:0] in_dst, in_src_a, in_src_b;
  logic       in_src_a_en, in_src_b_en;
  logic       stall, accept;

  always #2.5 clk = ~clk;

  iss_interlock u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_prod(in_prod), .in_cons(in_cons),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
    .in_src_b(in_src_b), .in_src_b_en(in_src_b_en), .stall(stall), .accept(accept)
  );

  // R1 encodings
  localparam logic [2:0] P_NONE = 3'd0, P_LOAD = 3'd1, P_ALU = 3'd2, P_MULG = 3'd3,
                         P_MFHL = 3'd4, P_MTHL = 3'd5, P_MULTI = 3'd6;
  localparam logic [1:0] C_PLAIN = 2'd0, C_ADDR = 2'd1, C_PREF = 2'd2, C_ACC = 2'd3;

  typedef struct {
    logic  st;
    logic  ac;
    string req;
  } exp_t;

  exp_t q[$];
  event smp_ev;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // Monitor: pops one expected item per sample and compares.
  initial begin
    forever begin
      @(smp_ev);
      if (q.size() != 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (stall !== it.st || accept !== it.ac) begin
          errors++;
          $display("FAIL %s stall=%0b accept=%0b expected stall=%0b accept=%0b",
                   it.req, stall, accept, it.st, it.ac);
        end
      end
    end
  end

  // Driver: presents one instruction per cycle and queues the expected result.
  task automatic present(input logic v, input logic [2:0] p, input logic [1:0] c,
                         input logic [4:0] d, input logic [4:0] sa, input logic ea,
                         input logic [4:0] sb, input logic eb, input logic exp_st,
                         input string r);
    exp_t it;
    @(negedge clk);
    in_valid = v; in_prod = p; in_cons = c; in_dst = d;
    in_src_a = sa; in_src_a_en = ea; in_src_b = sb; in_src_b_en = eb;
    #1;
    it.st = exp_st; it.ac = v & !exp_st; it.req = r;
    q.push_back(it);
    -> smp_ev;
  endtask

  task automatic issue(input logic [2:0] p, input logic [4:0] d, input string r);
    present(1'b1, p, C_PLAIN, d, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      present(1'b0, P_NONE, C_PLAIN, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, "R3");
  endtask

  // Present a consumer until accepted; it must be accepted at distance w.
  task automatic consume(input logic [1:0] c, input logic [4:0] sa, input logic ea,
                         input logic [4:0] sb, input logic eb, input int w,
                         input string r);
    for (int k = 1; k <= w; k++)
      present(1'b1, P_NONE, c, 5'd0, sa, ea, sb, eb, (k < w), r);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0; in_prod = '0; in_cons = '0; in_dst = '0;
    in_src_a = '0; in_src_a_en = 1'b0; in_src_b = '0; in_src_b_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2: nothing pending after reset
    consume(C_ADDR, 5'd31, 1'b1, 5'd30, 1'b1, 1, "R2");
    consume(C_ACC,  5'd5,  1'b1, 5'd6,  1'b1, 1, "R2");
    // R3: idle cycle never stalls
    idle(2);

    // R4: load ordinary 2, base 3, prefetch 3
    issue(P_LOAD, 5'd4, "R4"); consume(C_PLAIN, 5'd4, 1'b1, 5'd0, 1'b0, 2, "R4"); idle(6);
    issue(P_LOAD, 5'd4, "R4"); consume(C_ADDR,  5'd4, 1'b1, 5'd0, 1'b0, 3, "R4"); idle(6);
    issue(P_LOAD, 5'd4, "R4"); consume(C_PREF,  5'd4, 1'b1, 5'd0, 1'b0, 3, "R4"); idle(6);

    // R5: arithmetic and multi
    issue(P_ALU, 5'd7, "R5");   consume(C_PLAIN, 5'd0, 1'b0, 5'd7, 1'b1, 1, "R5"); idle(6);
    issue(P_ALU, 5'd7, "R5");   consume(C_ADDR,  5'd7, 1'b1, 5'd0, 1'b0, 2, "R5"); idle(6);
    issue(P_MULTI, 5'd8, "R5"); consume(C_PLAIN, 5'd8, 1'b1, 5'd0, 1'b0, 1, "R5"); idle(6);
    issue(P_MULTI, 5'd8, "R5"); consume(C_PREF,  5'd8, 1'b1, 5'd0, 1'b0, 2, "R5"); idle(6);

    // R6: multiply-to-register and move-from-HI/LO
    issue(P_MULG, 5'd9, "R6");  consume(C_PLAIN, 5'd9,  1'b1, 5'd0, 1'b0, 5, "R6"); idle(8);
    issue(P_MULG, 5'd9, "R6");  consume(C_ADDR,  5'd9,  1'b1, 5'd0, 1'b0, 6, "R6"); idle(8);
    issue(P_MFHL, 5'd31, "R6"); consume(C_PLAIN, 5'd0,  1'b0, 5'd31, 1'b1, 5, "R6"); idle(8);
    issue(P_MFHL, 5'd31, "R6"); consume(C_PREF,  5'd31, 1'b1, 5'd0, 1'b0, 6, "R6"); idle(8);

    // R7: store data on source B takes the ordinary load distance
    issue(P_LOAD, 5'd10, "R7"); consume(C_ADDR, 5'd1, 1'b1, 5'd10, 1'b1, 2, "R7"); idle(6);

    // R8: multiply result into an accumulate goes at distance 1
    issue(P_MULG, 5'd11, "R8"); consume(C_ACC, 5'd11, 1'b1, 5'd0, 1'b0, 1, "R8"); idle(8);
    // R8: a load feeding an accumulate keeps its ordinary distance
    issue(P_LOAD, 5'd11, "R8"); consume(C_ACC, 5'd11, 1'b1, 5'd0, 1'b0, 2, "R8"); idle(6);

    // R9: move to HI/LO then accumulate waits 2; ordinary consumers unaffected
    issue(P_MTHL, 5'd12, "R9"); consume(C_ACC,   5'd0,  1'b0, 5'd0, 1'b0, 2, "R9"); idle(4);
    issue(P_MTHL, 5'd12, "R9"); consume(C_ADDR,  5'd12, 1'b1, 5'd0, 1'b0, 1, "R9"); idle(4);

    // R10: register 0 never pending
    issue(P_MULG, 5'd0, "R10"); consume(C_ADDR, 5'd0, 1'b1, 5'd0, 1'b1, 1, "R10"); idle(8);

    // R11: a stalled producer is withdrawn and leaves no trace
    issue(P_LOAD, 5'd5, "R11");
    present(1'b1, P_LOAD, C_ADDR, 5'd9, 5'd5, 1'b1, 5'd0, 1'b0, 1'b1, "R11");
    present(1'b1, P_LOAD, C_ADDR, 5'd9, 5'd5, 1'b1, 5'd0, 1'b0, 1'b1, "R11");
    consume(C_ADDR, 5'd9, 1'b1, 5'd0, 1'b0, 1, "R11");
    idle(6);

    // R12: counts keep falling while another consumer is stalled
    issue(P_MULG, 5'd12, "R12");
    issue(P_LOAD, 5'd13, "R12");
    consume(C_ADDR, 5'd13, 1'b1, 5'd0, 1'b0, 3, "R12");
    consume(C_PLAIN, 5'd0, 1'b0, 5'd12, 1'b1, 1, "R12");
    idle(8);

    // R13: newer producer replaces the older entry
    issue(P_MULG, 5'd20, "R13");
    issue(P_ALU,  5'd20, "R13");
    consume(C_PLAIN, 5'd20, 1'b1, 5'd0, 1'b0, 1, "R13");
    idle(2);

    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule